// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Free-Running Timebase

This block is a watchdog for a 32-bit register bus with single-word reads and writes. A power-of-two interval of 2^N clock cycles, fixed when the chip is built, governs an internal interval counter. When the interval runs out the first time, the block raises a warning flag and pulses an interrupt. If software lets a second interval run out while the warning flag is still set, the block asserts a system reset request for a fixed number of cycles. It also sets a sticky cause flag, which software can read after the reboot.

Software arms the timer by setting two enable bits that sit in different registers, so one stray write cannot start or stop it. Software services the timer by writing ones to the flag bits. This clears the flags and restarts the interval. A third register exposes a 32-bit timebase that counts every clock, so software can check that the clock is alive. Two reset inputs are provided. The power-on reset clears everything. The warm reset, which the system drives while it reboots, leaves the cause flag and the running reset pulse untouched.

Top module: `wdg_top`

## Requirements
- R1: After power-on reset, the registers at byte offsets 0x0 and 0x4 read zero, and `irq` and `sys_rst_req` are low.
- R2: The interval counter advances only while both enables are set: bit 1 of the register at 0x0 and bit 0 of the register at 0x4. With either enable alone, no interrupt or reset ever occurs.
- R3: When the interval counter expires with the warning flag (bit 2 at 0x0) clear, the flag is set and `irq` is high for exactly one cycle. This happens 2^N cycles after the edge that enabled or serviced the timer, and no reset is requested.
- R4: When the counter expires again while the warning flag is still set, `sys_rst_req` rises and the cause flag (bit 3 at 0x0) is set. This happens 2^(N+1) cycles after the last service.
- R5: `sys_rst_req` stays high for exactly RST_HOLD cycles and then falls.
- R6: Writing 1 to bit 2 or bit 3 at 0x0 clears that flag and restarts the interval, so the next expiry is 2^N cycles after that write.
- R7: Writing 0 to bit 2 or bit 3 at 0x0 leaves those flags unchanged.
- R8: A read of offset 0x8 returns a 32-bit count that grows by one every clock cycle.
- R9: Clearing the enables stops the counter: no further interrupt or reset occurs, and the flags keep their values.
- R10: A warm reset clears both enables, the warning flag and the counter. It leaves the cause flag and a running reset pulse unchanged. Only power-on reset clears the cause flag.
- R11: Reads of any offset other than 0x0, 0x4 and 0x8 return zero.
- R12: A service write that takes effect on the same edge as an expiry wins: that expiry is discarded and the interval restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| warm_rst | input | 1 | Synchronous active-high system (warm) reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as `rd_en` |
| irq | output | 1 | One-cycle interrupt on the first expiry |
| sys_rst_req | output | 1 | System reset request, held RST_HOLD cycles |

## Verification
A register write takes effect at the rising edge that follows the strobe. Read data appears combinationally in the same cycle. `irq` is due exactly 2^N edges after the write that enabled or serviced the timer, and `sys_rst_req` is due exactly 2^(N+1) edges after it. The request then stays high for RST_HOLD edges. The bench runs with N=4, so each interval is sixteen cycles. It counts edges from the commit edge of each write and samples at the falling edge after the edge where a result is due. For every window it also checks that nothing fires early. A sweep of service writes at every offset inside the interval, and one service write placed on the expiry edge itself, confirm the restart timing.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int WORD_W = 32;

    // word indices (byte offset / 4)
    localparam int IDX_CTRL_A = 0;
    localparam int IDX_CTRL_B = 1;
    localparam int IDX_TBASE  = 2;

    // bit positions in the word at offset 0x0
    localparam int B_CAUSE  = 3;
    localparam int B_WARN   = 2;
    localparam int B_ARM_A  = 1;
    // bit position in the word at offset 0x4
    localparam int B_ARM_B  = 0;

    typedef struct packed {
        logic run;        // both enables set
        logic kick;       // restart interval
        logic clr_warn;   // clear warning flag
        logic clr_cause;  // clear cause flag
    } wdg_ctrl_t;

    typedef struct packed {
        logic warn;
        logic cause;
    } wdg_stat_t;

    function automatic logic [WORD_W-1:0] pack_ctrl_a(wdg_stat_t s, logic arm_a);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[B_CAUSE] = s.cause;
        w[B_WARN]  = s.warn;
        w[B_ARM_A] = arm_a;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ctrl_b(logic arm_b);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[B_ARM_B] = arm_b;
        return w;
    endfunction

endpackage

// File: rtl/wdg_timebase.sv
module wdg_timebase
    import wdg_pkg::*;
#(
    parameter int TB_W = WORD_W
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TB_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end

    assert_timebase_step_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> count == $past(count) + 1'b1);

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  wdg_stat_t         stat,
    input  logic [WORD_W-1:0] tbase,
    output wdg_ctrl_t         ctrl,
    output logic [WORD_W-1:0] rdata
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word;
    logic             sel_a, sel_b, sel_t;
    logic             arm_a, arm_b;
    logic             wr_a, wr_b;
    logic             unused_bits;

    assign word  = addr[ADDR_W-1:2];
    assign sel_a = (word == IDX_W'(IDX_CTRL_A));
    assign sel_b = (word == IDX_W'(IDX_CTRL_B));
    assign sel_t = (word == IDX_W'(IDX_TBASE));

    assign unused_bits = ^{addr[1:0], wdata};

    // writes are discarded while the system reset is active
    assign wr_a = wr_en && sel_a && !warm_rst;
    assign wr_b = wr_en && sel_b && !warm_rst;

    always_ff @(posedge clk) begin
        if (rst || warm_rst) begin
            arm_a <= 1'b0;
            arm_b <= 1'b0;
        end else begin
            if (wr_a) arm_a <= wdata[B_ARM_A];
            if (wr_b) arm_b <= wdata[B_ARM_B];
        end
    end

    always_comb begin
        ctrl           = '0;
        ctrl.run       = arm_a && arm_b;
        ctrl.clr_warn  = wr_a && wdata[B_WARN];
        ctrl.clr_cause = wr_a && wdata[B_CAUSE];
        ctrl.kick      = ctrl.clr_warn || ctrl.clr_cause;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (sel_a)      rdata = pack_ctrl_a(stat, arm_a);
            else if (sel_b) rdata = pack_ctrl_b(arm_b);
            else if (sel_t) rdata = tbase;
        end
    end

    assert_warm_disarms_R10: assert property (@(posedge clk) disable iff (rst)
        warm_rst |=> !ctrl.run);

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (!sel_a && !sel_b && !sel_t) |-> rdata == '0);

endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int INTERVAL_LOG2 = 16,
    parameter int RST_HOLD      = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      warm_rst,
    input  wdg_ctrl_t ctrl,
    output wdg_stat_t stat,
    output logic      irq,
    output logic      sys_rst_req
);

    localparam int HOLD_W = $clog2(RST_HOLD + 1);

    logic [INTERVAL_LOG2-1:0] cnt;
    logic [HOLD_W-1:0]        hold;
    logic                     expire;

    assign expire      = ctrl.run && !ctrl.kick && (cnt == '1);
    assign sys_rst_req = (hold != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            stat <= '0;
            irq  <= 1'b0;
            hold <= '0;
        end else begin
            irq <= 1'b0;
            if (hold != '0) hold <= hold - 1'b1;
            if (ctrl.clr_cause) stat.cause <= 1'b0;
            if (warm_rst) begin
                cnt       <= '0;
                stat.warn <= 1'b0;
            end else begin
                if (ctrl.clr_warn) stat.warn <= 1'b0;
                if (ctrl.kick || !ctrl.run) begin
                    cnt <= '0;
                end else if (expire) begin
                    cnt <= '0;
                    if (!stat.warn) begin
                        stat.warn <= 1'b1;
                        irq       <= 1'b1;
                    end else begin
                        stat.cause <= 1'b1;
                        hold       <= HOLD_W'(RST_HOLD);
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_irq_single_R3: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_idle_no_irq_R2: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |=> !irq);

    assert_req_sets_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_req) |-> stat.cause);

    assert_cause_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (warm_rst && stat.cause) |=> stat.cause);

    assert_kick_no_irq_R12: assert property (@(posedge clk) disable iff (rst)
        ctrl.kick |=> !irq && !$rose(sys_rst_req));

endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int ADDR_W        = 6,
    parameter int INTERVAL_LOG2 = 16,
    parameter int RST_HOLD      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq,
    output logic              sys_rst_req
);

    wdg_ctrl_t         ctrl;
    wdg_stat_t         stat;
    logic [WORD_W-1:0] tbase;

    wdg_timebase #(.TB_W(WORD_W)) u_tb (
        .clk   (clk),
        .rst   (rst),
        .count (tbase)
    );

    wdg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .warm_rst (warm_rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .stat     (stat),
        .tbase    (tbase),
        .ctrl     (ctrl),
        .rdata    (rdata)
    );

    wdg_core #(.INTERVAL_LOG2(INTERVAL_LOG2), .RST_HOLD(RST_HOLD)) u_core (
        .clk         (clk),
        .rst         (rst),
        .warm_rst    (warm_rst),
        .ctrl        (ctrl),
        .stat        (stat),
        .irq         (irq),
        .sys_rst_req (sys_rst_req)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !irq && !sys_rst_req);

endmodule

// File: tb/wdg_top_test.sv
module wdg_top_test;

    localparam int AW = 6;
    localparam int N  = 4;
    localparam int P  = 1 << N;
    localparam int H  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          warm_rst = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq, sys_rst_req;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;

    wdg_top #(.ADDR_W(AW), .INTERVAL_LOG2(N), .RST_HOLD(H)) uut (
        .clk(clk), .rst(rst), .warm_rst(warm_rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .sys_rst_req(sys_rst_req)
    );

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) irq_seen <= irq_seen + int'(irq);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; the write commits at the next rising edge
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // starts at the falling edge after the commit edge c; irq due after edge c+n
    task automatic expect_irq(input int n, input string tag);
        logic early;
        early = 1'b0;
        repeat (n - 1) begin
            @(negedge clk);
            if (irq || sys_rst_req) early = 1'b1;
        end
        chk({tag, " no early irq"}, 32'(early), 32'd0);
        @(negedge clk);
        chk({tag, " irq due"}, 32'(irq), 32'd1);
        chk({tag, " no reset at first expiry"}, 32'(sys_rst_req), 32'd0);
        @(negedge clk);
        chk({tag, " irq one cycle"}, 32'(irq), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int base;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(6'h0, v); chk("R1 reg0", v, 32'h0);
        rd(6'h4, v); chk("R1 reg1", v, 32'h0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 sys_rst_req", 32'(sys_rst_req), 32'd0);

        // R11 unmapped offsets
        rd(6'hC, v);  chk("R11 offset 0xC", v, 32'h0);
        rd(6'h10, v); chk("R11 offset 0x10", v, 32'h0);
        rd(6'h38, v); chk("R11 offset 0x38", v, 32'h0);

        // R8 timebase
        rd(6'h8, v); tick(1); rd(6'h8, v2);
        chk("R8 successive reads", v2, v + 32'd1);
        tick(5); rd(6'h8, v2);
        chk("R8 six cycles", v2, v + 32'd6);

        // R2 single enables
        base = irq_seen;
        wr(6'h0, 32'h2);
        tick(2 * P + 4);
        chk("R2 enable A alone irq", 32'(irq_seen - base), 32'd0);
        rd(6'h0, v); chk("R2 enable A alone flags", v, 32'h2);
        wr(6'h0, 32'h0);
        wr(6'h4, 32'h1);
        tick(2 * P + 4);
        chk("R2 enable B alone irq", 32'(irq_seen - base), 32'd0);
        chk("R2 enable B alone reset", 32'(sys_rst_req), 32'd0);
        rd(6'h0, v); chk("R2 enable B alone flags", v, 32'h0);
        rd(6'h4, v); chk("R2 reg1 readback", v, 32'h1);

        // R3 first expiry, commit edge c
        wr(6'h0, 32'h2);
        expect_irq(P, "R3");
        rd(6'h0, v); chk("R3 warning flag", v, 32'h6);

        // R4 second expiry at c+2P; now after c+P+1
        tick(P - 2);
        chk("R4 no early reset", 32'(sys_rst_req), 32'd0);
        tick(1);
        chk("R4 reset request", 32'(sys_rst_req), 32'd1);
        rd(6'h0, v); chk("R4 cause flag", v, 32'hE);
        // R5 hold length
        tick(H - 1);
        chk("R5 held last cycle", 32'(sys_rst_req), 32'd1);
        tick(1);
        chk("R5 released", 32'(sys_rst_req), 32'd0);

        // R9 stop
        wr(6'h4, 32'h0);
        wr(6'h0, 32'h0);
        base = irq_seen;
        tick(3 * P);
        chk("R9 stopped irq", 32'(irq_seen - base), 32'd0);
        chk("R9 stopped reset", 32'(sys_rst_req), 32'd0);
        rd(6'h0, v); chk("R9 flags kept", v, 32'hC);

        // R7 zero writes to flags
        wr(6'h0, 32'h0);
        rd(6'h0, v); chk("R7 zero write keeps flags", v, 32'hC);

        // R6 clear each flag by writing one
        wr(6'h0, 32'h4);
        rd(6'h0, v); chk("R6 clear warning", v, 32'h8);
        wr(6'h0, 32'h8);
        rd(6'h0, v); chk("R6 clear cause", v, 32'h0);

        // R6 sweep of service offsets
        wr(6'h4, 32'h1);
        wr(6'h0, 32'h2);
        base = irq_seen;
        for (int k = 1; k < P; k++) begin
            tick(k - 1);
            wr(6'h0, (k % 2 == 0) ? 32'h6 : 32'hA);
        end
        chk("R6 sweep no irq", 32'(irq_seen - base), 32'd0);
        rd(6'h0, v); chk("R6 sweep flags", v, 32'h2);
        expect_irq(P, "R6 restart");

        // R12 service on the expiry edge; last service d, now after d+P+1
        tick(P - 2);
        wr(6'h0, 32'h6);
        chk("R12 no reset", 32'(sys_rst_req), 32'd0);
        chk("R12 no irq", 32'(irq), 32'd0);
        rd(6'h0, v); chk("R12 flags", v, 32'h2);

        // R10 warm reset; service edge e = d+2P, now after e
        expect_irq(P, "R10 setup");
        tick(P - 1);
        chk("R10 setup reset", 32'(sys_rst_req), 32'd1);
        warm_rst = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0;
        chk("R10 pulse survives warm reset", 32'(sys_rst_req), 32'd1);
        rd(6'h0, v); chk("R10 cause kept, others cleared", v, 32'h8);
        rd(6'h4, v); chk("R10 enable B cleared", v, 32'h0);
        base = irq_seen;
        tick(2 * P + 2);
        chk("R10 disarmed", 32'(irq_seen - base), 32'd0);
        chk("R10 pulse ended", 32'(sys_rst_req), 32'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(6'h0, v); chk("R10 power-on clears cause", v, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule